// File: doc/BRIEF.md
# Strobe-Driven Slave Byte Port

This block lets an external bus master exchange bytes with the host logic over an 8-bit data bus. The master uses a chip select, a read strobe, a write strobe and an optional 2-bit byte address. Inside the block there are two separate four-byte buffers. The inbound buffer is filled by the master and drained by the host. The outbound buffer is filled by the host and drained by the master. Each byte carries its own occupancy flag. Both buffers also have an aggregate flag, and each has a sticky error bit that the host clears.

All external control lines are asynchronous to `clk`, so they pass through synchronizer chains. A write or read takes effect when the trailing edge of the strobe is detected with chip select still active. While a read strobe is active, the block drives the chosen outbound byte on `ext_dout` and raises `ext_oe`. The selection mode decides which byte a strobe touches:
- a single fixed byte;
- a pair of wrapping pointers, one for each direction;
- the address pins.

An interrupt pulse can be raised on every completed strobe or only on accesses to the last byte. Raising `en` reinitializes the pointers and every flag, but keeps the stored bytes.

Top module: `strobe_slave_port`

## Requirements
- R1: With `cfg_sel` at 00 or 11 (single mode), every external write lands in byte 0 and only `in_full[0]` can become set; no pointer moves.
- R2: While chip select and read are both active, `ext_oe` is 1 and `ext_dout` carries the selected outbound byte. `ext_oe` returns to 0 after the read strobe ends.
- R3: A completed external read sets `out_empty[i]` of the byte it read.
- R4: With `cfg_sel` = 01 (sequential mode), the write pointer and the read pointer each step through bytes 0,1,2,3 and then wrap to 0. Each pointer moves once per completed strobe of its own direction.
- R5: With `cfg_sel` = 10 (addressed mode), `ext_addr` picks the byte that a strobe writes or reads.
- R6: A write to an inbound byte that is already full keeps the old byte and sets `ovf`. `ovf` stays set until a `cpu_ovf_clr` pulse.
- R7: A read of an outbound byte that is already empty sets `unf`. `unf` stays set until a `cpu_unf_clr` pulse.
- R8: `in_all_full` is 1 only when all four `in_full` bits are 1. `out_all_empty` is 1 only when all four `out_empty` bits are 1.
- R9: A host read (`cpu_in_rd`) returns the byte selected by `cpu_in_sel` on `cpu_in_rdata` one cycle later and clears that byte's full flag. A host write (`cpu_out_wr`) stores a byte and clears its empty flag.
- R10: `cfg_irq` controls the one-cycle `irq` pulse as follows:
  - 01: a pulse for every completed strobe;
  - 11: a pulse only for an access to byte 3;
  - 00 and 10: no pulse.
- R11: While `en` is 0, strobes do nothing and `ext_oe` stays 0. On a rise of `en`, the pointers return to 0, `in_full` becomes 0000, `out_empty` becomes 1111, and `ovf` and `unf` are cleared. Buffer contents are kept.
- R12: Strobes while `ext_cs` is 0 change no flag, produce no interrupt and do not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; a rising edge reinitializes pointers and flags |
| cfg_sel | input | 2 | Byte selection mode |
| cfg_irq | input | 2 | Interrupt mode |
| ext_cs | input | 1 | External chip select, active high, asynchronous |
| ext_rd | input | 1 | External read strobe, active high, asynchronous |
| ext_wr | input | 1 | External write strobe, active high, asynchronous |
| ext_addr | input | 2 | External byte address (addressed mode) |
| ext_din | input | 8 | Data from the external master |
| ext_dout | output | 8 | Outbound byte driven toward the master |
| ext_oe | output | 1 | Bus drive enable for `ext_dout` |
| cpu_in_rd | input | 1 | Host read pulse for the inbound buffer |
| cpu_in_sel | input | 2 | Inbound byte index for host reads |
| cpu_in_rdata | output | 8 | Inbound byte, one cycle after the read pulse |
| cpu_out_wr | input | 1 | Host write pulse for the outbound buffer |
| cpu_out_sel | input | 2 | Outbound byte index for host writes |
| cpu_out_wdata | input | 8 | Outbound byte value |
| cpu_ovf_clr | input | 1 | Clears the overflow flag |
| cpu_unf_clr | input | 1 | Clears the underflow flag |
| in_full | output | 4 | Per-byte inbound full flags, bit i for byte i |
| in_all_full | output | 1 | All inbound bytes full |
| out_empty | output | 4 | Per-byte outbound empty flags, bit i for byte i |
| out_all_empty | output | 1 | All outbound bytes empty |
| ovf | output | 1 | Sticky inbound overflow |
| unf | output | 1 | Sticky outbound underflow |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A pointer that skips or fails to wrap shows at the ports within one strobe:
- the full flag of the wrong byte rises;
- the wrong byte appears on `ext_dout`;
- the interrupt lands on the wrong access.

A lost reinitialization on `en` leaves stale flags visible right after the rise, and a stale pointer shows on the next strobe. A broken discard rule shows only later, when the host reads back the overwritten byte, so that readback is checked after every overflow. Sweeps run every selection mode and every interrupt mode against byte-order permutations computed in the bench.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    SEL_SINGLE = 2'b00,
    SEL_SEQ    = 2'b01,
    SEL_ADDR   = 2'b10,
    SEL_SINGLE2 = 2'b11
  } sel_mode_e;

  typedef enum logic [1:0] {
    IRQ_OFF  = 2'b00,
    IRQ_EACH = 2'b01,
    IRQ_RSVD = 2'b10,
    IRQ_LAST = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/ssp_sync.sv
// Multi-flop synchronizer chain for asynchronous inputs.
module ssp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], async_i};
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/ssp_bank.sv
// Byte buffer with per-entry occupancy flag. IS_INPUT selects the variant:
// 1 = writes to an occupied entry are dropped and reported,
// 0 = writes always store; takes of an unoccupied entry are reported.
module ssp_bank #(
  parameter int W        = 8,
  parameter int DEPTH    = 4,
  parameter bit IS_INPUT = 1'b1,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             take_en,
  input  logic [AW-1:0]    take_idx,
  input  logic [AW-1:0]    rd_idx,
  output logic [W-1:0]     rd_data,
  output logic [DEPTH-1:0] valid,
  output logic             err
);
  logic [W-1:0] mem [DEPTH];
  logic         store;

  if (IS_INPUT) begin : g_in
    assign store = wr_en & ~valid[wr_idx];
    assign err   = wr_en &  valid[wr_idx];
  end else begin : g_out
    assign store = wr_en;
    assign err   = take_en & ~valid[take_idx];
  end

  always_ff @(posedge clk) begin
    if (store) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_idx];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst || clear)                          flag_q <= 1'b0;
      else if (wr_en && wr_idx == AW'(g))        flag_q <= 1'b1;
      else if (take_en && take_idx == AW'(g))    flag_q <= 1'b0;
    end
    assign valid[g] = flag_q;
  end
endmodule

// File: rtl/ssp_ctrl.sv
// Strobe edge detection, byte selection, pointers, sticky errors, interrupt.
module ssp_ctrl import ssp_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    sel_mode,
  input  logic [1:0]    irq_mode,
  input  logic          cs_s,
  input  logic          rd_s,
  input  logic          wr_s,
  input  logic          cs_q,
  input  logic          rd_q,
  input  logic          wr_q,
  input  logic [AW-1:0] addr_q,
  input  logic          in_err,
  input  logic          out_err,
  input  logic          ovf_clr,
  input  logic          unf_clr,
  output logic          init,
  output logic          wr_ev,
  output logic          rd_ev,
  output logic [AW-1:0] in_idx,
  output logic [AW-1:0] out_idx,
  output logic          oe,
  output logic          irq,
  output logic          ovf,
  output logic          unf
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic          en_q;
  logic          live;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          any_ev, last_ev;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en;
  end

  assign init  = en & ~en_q;
  assign live  = en & en_q;
  assign wr_ev = live & cs_q & wr_q & ~wr_s;
  assign rd_ev = live & cs_q & rd_q & ~rd_s;

  always_comb begin
    case (sel_mode)
      SEL_SEQ:  begin in_idx = wr_ptr; out_idx = rd_ptr; end
      SEL_ADDR: begin in_idx = addr_q; out_idx = addr_q; end
      default:  begin in_idx = '0;     out_idx = '0;     end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (sel_mode == SEL_SEQ) begin
      if (wr_ev) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (rd_ev) rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
    end
  end

  assign any_ev  = wr_ev | rd_ev;
  assign last_ev = (wr_ev && in_idx == LAST_IDX) || (rd_ev && out_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      oe  <= 1'b0;
    end else begin
      oe <= live & cs_s & rd_s;
      case (irq_mode)
        IRQ_EACH: irq <= any_ev;
        IRQ_LAST: irq <= last_ev;
        default:  irq <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init)  ovf <= 1'b0;
    else if (in_err)  ovf <= 1'b1;
    else if (ovf_clr) ovf <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || init)  unf <= 1'b0;
    else if (out_err) unf <= 1'b1;
    else if (unf_clr) unf <= 1'b0;
  end
endmodule

// File: rtl/strobe_slave_port.sv
module strobe_slave_port #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        cfg_sel,
  input  logic [1:0]        cfg_irq,
  input  logic              ext_cs,
  input  logic              ext_rd,
  input  logic              ext_wr,
  input  logic [AW-1:0]     ext_addr,
  input  logic [DATA_W-1:0] ext_din,
  output logic [DATA_W-1:0] ext_dout,
  output logic              ext_oe,
  input  logic              cpu_in_rd,
  input  logic [AW-1:0]     cpu_in_sel,
  output logic [DATA_W-1:0] cpu_in_rdata,
  input  logic              cpu_out_wr,
  input  logic [AW-1:0]     cpu_out_sel,
  input  logic [DATA_W-1:0] cpu_out_wdata,
  input  logic              cpu_ovf_clr,
  input  logic              cpu_unf_clr,
  output logic [DEPTH-1:0]  in_full,
  output logic              in_all_full,
  output logic [DEPTH-1:0]  out_empty,
  output logic              out_all_empty,
  output logic              ovf,
  output logic              unf,
  output logic              irq
);
  localparam int BUS_W = AW + DATA_W;

  // Strobes: synchronized value and one further stage for edge detection.
  logic [2:0]       strb_s, strb_q;
  // Address and data are delayed one stage more so they line up with strb_q.
  logic [BUS_W-1:0] bus_q;

  ssp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_strb (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ext_cs, ext_rd, ext_wr}),
    .sync_o  (strb_s)
  );

  always_ff @(posedge clk) begin
    if (rst) strb_q <= '0;
    else     strb_q <= strb_s;
  end

  ssp_sync #(.W(BUS_W), .STAGES(SYNC_STAGES + 1)) u_sync_bus (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ext_addr, ext_din}),
    .sync_o  (bus_q)
  );

  logic              init, wr_ev, rd_ev, in_err, out_err;
  logic [AW-1:0]     in_idx, out_idx;
  logic [DEPTH-1:0]  in_valid, out_valid;

  ssp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .sel_mode (cfg_sel),
    .irq_mode (cfg_irq),
    .cs_s     (strb_s[2]),
    .rd_s     (strb_s[1]),
    .wr_s     (strb_s[0]),
    .cs_q     (strb_q[2]),
    .rd_q     (strb_q[1]),
    .wr_q     (strb_q[0]),
    .addr_q   (bus_q[BUS_W-1:DATA_W]),
    .in_err   (in_err),
    .out_err  (out_err),
    .ovf_clr  (cpu_ovf_clr),
    .unf_clr  (cpu_unf_clr),
    .init     (init),
    .wr_ev    (wr_ev),
    .rd_ev    (rd_ev),
    .in_idx   (in_idx),
    .out_idx  (out_idx),
    .oe       (ext_oe),
    .irq      (irq),
    .ovf      (ovf),
    .unf      (unf)
  );

  ssp_bank #(.W(DATA_W), .DEPTH(DEPTH), .IS_INPUT(1'b1)) u_in_bank (
    .clk      (clk),
    .rst      (rst),
    .clear    (init),
    .wr_en    (wr_ev),
    .wr_idx   (in_idx),
    .wr_data  (bus_q[DATA_W-1:0]),
    .take_en  (cpu_in_rd),
    .take_idx (cpu_in_sel),
    .rd_idx   (cpu_in_sel),
    .rd_data  (cpu_in_rdata),
    .valid    (in_valid),
    .err      (in_err)
  );

  ssp_bank #(.W(DATA_W), .DEPTH(DEPTH), .IS_INPUT(1'b0)) u_out_bank (
    .clk      (clk),
    .rst      (rst),
    .clear    (init),
    .wr_en    (cpu_out_wr),
    .wr_idx   (cpu_out_sel),
    .wr_data  (cpu_out_wdata),
    .take_en  (rd_ev),
    .take_idx (out_idx),
    .rd_idx   (out_idx),
    .rd_data  (ext_dout),
    .valid    (out_valid),
    .err      (out_err)
  );

  assign in_full       = in_valid;
  assign out_empty     = ~out_valid;
  assign in_all_full   = &in_valid;
  assign out_all_empty = ~|out_valid;
endmodule

// File: rtl/ssp_checks.sv
module ssp_checks #(
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [1:0]       cfg_sel,
  input logic [1:0]       cfg_irq,
  input logic             irq,
  input logic             ovf,
  input logic             unf,
  input logic             cpu_ovf_clr,
  input logic             cpu_unf_clr,
  input logic [DEPTH-1:0] in_full,
  input logic [DEPTH-1:0] out_empty,
  input logic             ext_oe,
  input logic             init,
  input logic             wr_ev
);
  AST_IRQ_MODE_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(cfg_irq) == 2'b01 || $past(cfg_irq) == 2'b11)); // R10

  AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($past(ovf) && !$past(cpu_ovf_clr) && !$past(init)) |-> ovf); // R6

  AST_UNF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($past(unf) && !$past(cpu_unf_clr) && !$past(init)) |-> unf); // R7

  AST_INIT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(init) |-> (in_full == '0 && out_empty == '1 && !ovf && !unf)); // R11

  AST_FULL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    ((in_full & ~$past(in_full)) != '0) |-> $past(wr_ev)); // R1

  AST_SINGLE_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_sel) == 2'b00 || $past(cfg_sel) == 2'b11)
      |-> (((in_full & ~$past(in_full)) >> 1) == '0)); // R1

  AST_OE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ext_oe |-> $past(en)); // R11
endmodule

bind strobe_slave_port ssp_checks #(.DEPTH(DEPTH)) u_checks (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .cfg_sel     (cfg_sel),
  .cfg_irq     (cfg_irq),
  .irq         (irq),
  .ovf         (ovf),
  .unf         (unf),
  .cpu_ovf_clr (cpu_ovf_clr),
  .cpu_unf_clr (cpu_unf_clr),
  .in_full     (in_full),
  .out_empty   (out_empty),
  .ext_oe      (ext_oe),
  .init        (init),
  .wr_ev       (wr_ev)
);

// File: tb/test_strobe_slave_port.sv
module test_strobe_slave_port;
  localparam int HALF = 2500; // 2.5 ns in 1 ps units -> 200 MHz

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] cfg_sel = 2'b00;
  logic [1:0] cfg_irq = 2'b00;
  logic       ext_cs = 1'b0, ext_rd = 1'b0, ext_wr = 1'b0;
  logic [1:0] ext_addr = 2'b00;
  logic [7:0] ext_din = 8'h00;
  logic [7:0] ext_dout;
  logic       ext_oe;
  logic       cpu_in_rd = 1'b0;
  logic [1:0] cpu_in_sel = 2'b00;
  logic [7:0] cpu_in_rdata;
  logic       cpu_out_wr = 1'b0;
  logic [1:0] cpu_out_sel = 2'b00;
  logic [7:0] cpu_out_wdata = 8'h00;
  logic       cpu_ovf_clr = 1'b0, cpu_unf_clr = 1'b0;
  logic [3:0] in_full, out_empty;
  logic       in_all_full, out_all_empty, ovf, unf, irq;

  int n_chk = 0;
  int n_fail = 0;
  int irq_seen = 0;

  always #HALF clk = ~clk;
  always @(negedge clk) if (irq) irq_seen++;

  strobe_slave_port i_strobe_slave_port (
    .clk(clk), .rst(rst), .en(en), .cfg_sel(cfg_sel), .cfg_irq(cfg_irq),
    .ext_cs(ext_cs), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_addr(ext_addr),
    .ext_din(ext_din), .ext_dout(ext_dout), .ext_oe(ext_oe),
    .cpu_in_rd(cpu_in_rd), .cpu_in_sel(cpu_in_sel), .cpu_in_rdata(cpu_in_rdata),
    .cpu_out_wr(cpu_out_wr), .cpu_out_sel(cpu_out_sel), .cpu_out_wdata(cpu_out_wdata),
    .cpu_ovf_clr(cpu_ovf_clr), .cpu_unf_clr(cpu_unf_clr),
    .in_full(in_full), .in_all_full(in_all_full), .out_empty(out_empty),
    .out_all_empty(out_all_empty), .ovf(ovf), .unf(unf), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ext_write(input logic [1:0] a, input logic [7:0] d, input bit cs);
    ext_addr = a; ext_din = d; ext_cs = cs;
    tick(1); ext_wr = 1'b1;
    tick(3); ext_wr = 1'b0;
    tick(4); ext_cs = 1'b0;
    tick(2);
  endtask

  task automatic ext_read(input logic [1:0] a, input bit cs,
                          output logic [7:0] d, output logic oe_on, output logic oe_off);
    ext_addr = a; ext_cs = cs;
    tick(1); ext_rd = 1'b1;
    tick(4); d = ext_dout; oe_on = ext_oe;
    ext_rd = 1'b0;
    tick(4); oe_off = ext_oe;
    ext_cs = 1'b0;
    tick(2);
  endtask

  task automatic cpu_read(input logic [1:0] i, output logic [7:0] d);
    cpu_in_sel = i; cpu_in_rd = 1'b1;
    tick(1); cpu_in_rd = 1'b0; d = cpu_in_rdata;
  endtask

  task automatic cpu_write(input logic [1:0] i, input logic [7:0] d);
    cpu_out_sel = i; cpu_out_wdata = d; cpu_out_wr = 1'b1;
    tick(1); cpu_out_wr = 1'b0;
  endtask

  task automatic clear_flags();
    cpu_ovf_clr = 1'b1; cpu_unf_clr = 1'b1;
    tick(1); cpu_ovf_clr = 1'b0; cpu_unf_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       on, off;
    int         b;
    int         acc;

    tick(3); rst = 1'b0; tick(1);
    chk("R11", "reset in_full", int'(in_full), 0);
    chk("R11", "reset out_empty", int'(out_empty), 'hF);
    chk("R7", "reset ovf/unf", int'({ovf, unf}), 0);
    chk("R2", "reset oe", int'(ext_oe), 0);
    en = 1'b1; tick(2);

    // Single mode, interrupt on every strobe
    cfg_sel = 2'b00; cfg_irq = 2'b01;
    b = irq_seen; ext_write(2'd3, 8'hA5, 1'b1);
    chk("R1", "single write in_full", int'(in_full), 'h1);
    chk("R10", "each-strobe irq", irq_seen - b, 1);
    b = irq_seen; ext_write(2'd1, 8'h3C, 1'b1);
    chk("R6", "overflow set", int'(ovf), 1);
    chk("R1", "no pointer move", int'(in_full), 'h1);
    chk("R10", "irq on overflowing strobe", irq_seen - b, 1);
    cpu_read(2'd0, d);
    chk("R6", "discarded byte kept", int'(d), 'hA5);
    chk("R9", "host read clears full", int'(in_full), 0);
    chk("R6", "ovf sticky", int'(ovf), 1);
    clear_flags();
    chk("R6", "ovf cleared", int'(ovf), 0);
    cpu_write(2'd0, 8'h5A);
    chk("R9", "host write clears empty", int'(out_empty), 'hE);
    chk("R8", "out_all_empty low", int'(out_all_empty), 0);
    ext_read(2'd2, 1'b1, d, on, off);
    chk("R2", "read data", int'(d), 'h5A);
    chk("R2", "oe during read", int'(on), 1);
    chk("R2", "oe after read", int'(off), 0);
    chk("R3", "empty after read", int'(out_empty), 'hF);
    chk("R7", "no underflow", int'(unf), 0);
    ext_read(2'd0, 1'b1, d, on, off);
    chk("R7", "underflow set", int'(unf), 1);
    clear_flags();
    chk("R7", "unf cleared", int'(unf), 0);

    // Sequential mode, interrupt on byte 3 only
    cfg_sel = 2'b01; cfg_irq = 2'b11;
    for (int k = 0; k < 4; k++) cpu_write(2'(k), 8'(8'h10 + k));
    for (int k = 0; k < 5; k++) begin
      b = irq_seen;
      ext_read(2'd0, 1'b1, d, on, off);
      chk("R4", "sequential read data", int'(d), 'h10 + (k % 4));
      chk("R10", "last-byte irq on read", irq_seen - b, (k == 3) ? 1 : 0);
      if (k == 3) chk("R8", "out_all_empty", int'(out_all_empty), 1);
    end
    chk("R7", "wrap read underflow", int'(unf), 1);
    clear_flags();
    for (int k = 0; k < 5; k++) begin
      b = irq_seen;
      ext_write(2'd2, 8'(8'h20 + k), 1'b1);
      chk("R10", "last-byte irq on write", irq_seen - b, (k == 3) ? 1 : 0);
      if (k == 2) chk("R8", "in_all_full low", int'(in_all_full), 0);
      if (k < 4) chk("R4", "sequential in_full", int'(in_full), (1 << (k + 1)) - 1);
    end
    chk("R8", "in_all_full", int'(in_all_full), 1);
    chk("R6", "wrap write overflow", int'(ovf), 1);
    for (int k = 0; k < 4; k++) begin
      cpu_read(2'(k), d);
      chk("R4", "sequential stored byte", int'(d), 'h20 + k);
    end
    chk("R9", "all drained", int'(in_full), 0);
    clear_flags();

    // Addressed mode, permuted order
    cfg_sel = 2'b10; cfg_irq = 2'b11;
    acc = 0;
    for (int k = 0; k < 4; k++) begin
      int a;
      a = (k * 3 + 2) % 4;
      b = irq_seen;
      ext_write(2'(a), 8'(8'h40 + a), 1'b1);
      acc = acc | (1 << a);
      chk("R5", "addressed in_full", int'(in_full), acc);
      chk("R10", "irq only at address 3", irq_seen - b, (a == 3) ? 1 : 0);
    end
    for (int k = 0; k < 4; k++) begin
      cpu_read(2'(k), d);
      chk("R5", "addressed stored byte", int'(d), 'h40 + k);
    end
    cfg_irq = 2'b01;
    for (int k = 0; k < 4; k++) cpu_write(2'(k), 8'(8'h60 + k));
    acc = 0;
    for (int k = 0; k < 4; k++) begin
      int a;
      a = 3 - k;
      b = irq_seen;
      ext_read(2'(a), 1'b1, d, on, off);
      acc = acc | (1 << a);
      chk("R5", "addressed read data", int'(d), 'h60 + a);
      chk("R3", "addressed empty flags", int'(out_empty), acc);
      chk("R10", "each-strobe irq on read", irq_seen - b, 1);
    end
    ext_read(2'd1, 1'b1, d, on, off);
    chk("R7", "addressed underflow", int'(unf), 1);
    clear_flags();

    // Chip select inactive
    b = irq_seen;
    ext_write(2'd1, 8'h55, 1'b0);
    chk("R12", "no cs write ignored", int'(in_full), 0);
    chk("R12", "no cs no irq", irq_seen - b, 0);
    cpu_write(2'd1, 8'h66);
    ext_read(2'd1, 1'b0, d, on, off);
    chk("R12", "no cs no drive", int'(on), 0);
    chk("R12", "no cs keeps byte", int'(out_empty), 'hD);

    // Quiet interrupt modes
    cfg_irq = 2'b00; b = irq_seen;
    ext_write(2'd2, 8'h77, 1'b1);
    chk("R10", "mode 00 silent", irq_seen - b, 0);
    cfg_irq = 2'b10; b = irq_seen;
    ext_write(2'd3, 8'h88, 1'b1);
    chk("R10", "mode 10 silent", irq_seen - b, 0);
    ext_write(2'd2, 8'h99, 1'b1);
    chk("R6", "overflow before disable", int'(ovf), 1);

    // Disable and re-enable
    en = 1'b0; tick(2);
    ext_write(2'd1, 8'h11, 1'b1);
    chk("R11", "disabled write ignored", int'(in_full), 'hC);
    chk("R11", "flags retained while off", int'(ovf), 1);
    ext_read(2'd1, 1'b1, d, on, off);
    chk("R11", "disabled no drive", int'(on), 0);
    en = 1'b1; tick(2);
    chk("R11", "enable clears in_full", int'(in_full), 0);
    chk("R11", "enable sets out_empty", int'(out_empty), 'hF);
    chk("R11", "enable clears ovf/unf", int'({ovf, unf}), 0);
    cpu_read(2'd2, d);
    chk("R11", "contents kept", int'(d), 'h77);
    cfg_sel = 2'b01;
    ext_write(2'd3, 8'hAB, 1'b1);
    chk("R11", "write pointer reset", int'(in_full), 'h1);
    cpu_write(2'd0, 8'hCD);
    ext_read(2'd2, 1'b1, d, on, off);
    chk("R11", "read pointer reset", int'(d), 'hCD);

    // Single mode via code 11
    en = 1'b0; tick(2); en = 1'b1; tick(2);
    cfg_sel = 2'b11;
    ext_write(2'd2, 8'hEE, 1'b1);
    chk("R1", "code 11 acts as single", int'(in_full), 'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule